// File: doc/BRIEF.md
# Audio Link Transmit Channel Serializer

This block is one transmit channel of a serial audio link controller. Software writes a PCM sample through a write port into a holding register. The write port takes the sample width, from 10 to 20 bits, and the byte order of the sample. When an external frame sequencer strobes the start of this channel's slot, the held sample moves into a shift register. It then leaves the block on a single serial line, one bit per link bit clock, most significant bit first, inside a fixed 20-bit slot.

A ready flag tells software when the holding register can take the next sample. A level interrupt follows that flag through a mask. If a slot starts with no sample waiting, the block sends an all-zero slot and records a sticky underrun bit. A global enable and a channel enable must both be set for the channel to accept samples or transmit. Dropping the channel enable flushes any waiting sample.

Top module: `aclink_tx_lane`

## Requirements
- R1: The width field `size_sel` selects the sample width: 00 = 10 bits, 01 = 16 bits, 10 = 18 bits, 11 = 20 bits. The width is applied when the sample is written. The low bits of the (reordered) write data are placed left-justified in the 20-bit slot, and the unused low slot bits are zero.
- R2: When `slot_go` is sampled high at a clock edge, slot bit 19 appears on `sdata` after that edge. Bits 18 down to 0 follow on the next 19 edges. `sdata` is low after the last bit until the next slot.
- R3: With `little_end` = 1, the write data bytes are reordered before truncation. For 10-bit and 16-bit samples, bytes 0 and 1 are swapped. For 18-bit and 20-bit samples, bytes 0, 1 and 2 are reversed. With `little_end` = 0, the data is used as written.
- R4: `tx_rdy` is 1 after reset. It is set at the clock edge where a held sample moves into the shift register on `slot_go`.
- R5: A write (`wr_en`) while the channel is active fills the holding register and clears `tx_rdy` at that edge.
- R6: `rdy_irq` is high exactly while `tx_rdy` is 1 and `rdy_irq_en` is 1.
- R7: A `slot_go` with an empty holding register sends 20 zero bits and sets `underrun`. The bit stays set until a `stat_rd` pulse clears it.
- R8: Unless both `glb_en` and `lane_en` are 1, writes and slot strobes are ignored: no sample is stored, `sdata` stays low, and `underrun` is not set.
- R9: Clearing `lane_en` empties the holding register, sets `tx_rdy` and drives `sdata` low from the next edge, including in the middle of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glb_en | input | 1 | Controller-wide enable |
| lane_en | input | 1 | Channel enable |
| size_sel | input | 2 | Sample width select (see R1) |
| little_end | input | 1 | 1 = written data is little-endian |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 24 | Sample data as written by software |
| slot_go | input | 1 | Slot start strobe from the frame sequencer |
| stat_rd | input | 1 | Status read pulse, clears underrun |
| rdy_irq_en | input | 1 | Ready interrupt mask, 1 = enabled |
| sdata | output | 1 | Serial slot data, MSB first |
| tx_rdy | output | 1 | Holding register can accept a sample |
| rdy_irq | output | 1 | Level interrupt for tx_rdy |
| underrun | output | 1 | Sticky empty-slot status |

## Verification
Flag results are due one edge after their stimulus. The effect of a write, strobe, status read or enable change is sampled on the falling edge that follows the next rising edge. Serial bits are due starting with the rising edge that samples `slot_go`. The driver pushes the 20 expected slot bits, plus a trailing low bit where the slot runs to completion, into a queue in the same half-cycle it raises the strobe. A monitor then pops one bit 2 ns after every rising edge, so each bit is compared in the cycle it must appear. Disable and underrun cases push zero bits, so an idle or flushed line is checked bit by bit as well.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int SLOT_W = 20;
  localparam int DATA_W = 24;
  localparam int CNT_W  = $clog2(SLOT_W + 1);

  typedef enum logic [1:0] {
    SZ10 = 2'b00,
    SZ16 = 2'b01,
    SZ18 = 2'b10,
    SZ20 = 2'b11
  } size_e;
endpackage

// File: rtl/aclink_fmt.sv
module aclink_fmt
  import aclink_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size_sel,
  input  logic              little_end,
  output logic [SLOT_W-1:0] slot
);
  logic [DATA_W-1:0] reord;
  size_e             sz;

  assign sz = size_e'(size_sel);

  // byte reorder ahead of truncation
  always_comb begin
    reord = din;
    if (little_end) begin
      if (sz == SZ10 || sz == SZ16)
        reord = {din[23:16], din[7:0], din[15:8]};
      else
        reord = {din[7:0], din[15:8], din[23:16]};
    end
  end

  // left-justify, zero-fill the low slot bits
  always_comb begin
    case (sz)
      SZ10:    slot = {reord[9:0],  10'b0};
      SZ16:    slot = {reord[15:0], 4'b0};
      SZ18:    slot = {reord[17:0], 2'b0};
      default: slot = reord[SLOT_W-1:0];
    endcase
  end
endmodule

// File: rtl/aclink_hold.sv
module aclink_hold
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              slot_go,
  input  logic              stat_rd,
  output logic              load,
  output logic [SLOT_W-1:0] load_data,
  output logic              tx_rdy,
  output logic              underrun
);
  logic [SLOT_W-1:0] hold_q, hold_n;
  logic              full_q, full_n;
  logic              rdy_q, rdy_n;
  logic              unr_q, unr_n;

  assign load      = active & slot_go;
  assign load_data = full_q ? hold_q : '0;
  assign tx_rdy    = rdy_q;
  assign underrun  = unr_q;

  always_comb begin
    hold_n = hold_q;
    full_n = full_q;
    rdy_n  = rdy_q;
    unr_n  = unr_q & ~stat_rd;
    if (!active) begin
      full_n = 1'b0;
      rdy_n  = 1'b1;
    end else begin
      if (slot_go) begin
        if (full_q) begin
          full_n = 1'b0;
          rdy_n  = 1'b1;
        end else begin
          unr_n  = 1'b1;
        end
      end
      if (wr_en) begin
        hold_n = wr_slot;
        full_n = 1'b1;
        rdy_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      rdy_q  <= 1'b1;
      unr_q  <= 1'b0;
    end else begin
      hold_q <= hold_n;
      full_q <= full_n;
      rdy_q  <= rdy_n;
      unr_q  <= unr_n;
    end
  end
endmodule

// File: rtl/aclink_shift.sv
module aclink_shift
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic [SLOT_W-1:0] load_data,
  output logic              sdata
);
  logic [SLOT_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              out_q, out_n;

  assign sdata = out_q;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    out_n = 1'b0;
    if (!active) begin
      sh_n  = '0;
      cnt_n = '0;
    end else if (load) begin
      out_n = load_data[SLOT_W-1];
      sh_n  = {load_data[SLOT_W-2:0], 1'b0};
      cnt_n = CNT_W'(SLOT_W - 1);
    end else if (cnt_q != '0) begin
      out_n = sh_q[SLOT_W-1];
      sh_n  = {sh_q[SLOT_W-2:0], 1'b0};
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      out_q <= out_n;
    end
  end
endmodule

// File: rtl/aclink_tx_lane.sv
module aclink_tx_lane
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              lane_en,
  input  logic [1:0]        size_sel,
  input  logic              little_end,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slot_go,
  input  logic              stat_rd,
  input  logic              rdy_irq_en,
  output logic              sdata,
  output logic              tx_rdy,
  output logic              rdy_irq,
  output logic              underrun
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              active;
  logic [SLOT_W-1:0] wr_slot;
  logic              load;
  logic [SLOT_W-1:0] load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign active  = glb_en & lane_en;
  assign rdy_irq = tx_rdy & rdy_irq_en;

  aclink_fmt u_fmt (
    .din        (wr_data),
    .size_sel   (size_sel),
    .little_end (little_end),
    .slot       (wr_slot)
  );

  aclink_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active    (active),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .slot_go   (slot_go),
    .stat_rd   (stat_rd),
    .load      (load),
    .load_data (load_data),
    .tx_rdy    (tx_rdy),
    .underrun  (underrun)
  );

  aclink_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active    (active),
    .load      (load),
    .load_data (load_data),
    .sdata     (sdata)
  );
endmodule

// File: rtl/aclink_tx_lane_chk.sv
module aclink_tx_lane_chk (
  input logic clk,
  input logic rst_n,
  input logic glb_en,
  input logic lane_en,
  input logic wr_en,
  input logic slot_go,
  input logic stat_rd,
  input logic rdy_irq_en,
  input logic sdata,
  input logic tx_rdy,
  input logic rdy_irq,
  input logic underrun
);
  p_load_sets_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && lane_en && slot_go && !wr_en) |=> tx_rdy);

  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && lane_en && wr_en) |=> !tx_rdy);

  p_irq_needs_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_irq |-> (tx_rdy && rdy_irq_en));

  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rdy && rdy_irq_en) |-> rdy_irq);

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !stat_rd) |=> underrun);

  p_underrun_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(glb_en && lane_en && slot_go)) |=> !underrun);

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(glb_en && lane_en) |=> !sdata);

  p_no_underrun_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(glb_en && lane_en) && !underrun) |=> !underrun);

  p_flush_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |=> tx_rdy);
endmodule

bind aclink_tx_lane aclink_tx_lane_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .glb_en     (glb_en),
  .lane_en    (lane_en),
  .wr_en      (wr_en),
  .slot_go    (slot_go),
  .stat_rd    (stat_rd),
  .rdy_irq_en (rdy_irq_en),
  .sdata      (sdata),
  .tx_rdy     (tx_rdy),
  .rdy_irq    (rdy_irq),
  .underrun   (underrun)
);

// File: tb/aclink_tx_lane_bench.sv
`timescale 1ns/1ps
module aclink_tx_lane_bench;
  logic        clk;
  logic        rst_n;
  logic        glb_en, lane_en;
  logic [1:0]  size_sel;
  logic        little_end;
  logic        wr_en;
  logic [23:0] wr_data;
  logic        slot_go;
  logic        stat_rd;
  logic        rdy_irq_en;
  logic        sdata, tx_rdy, rdy_irq, underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_q[$];
  string tag_q[$];

  aclink_tx_lane u_aclink_tx_lane (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .lane_en(lane_en),
    .size_sel(size_sel), .little_end(little_end), .wr_en(wr_en),
    .wr_data(wr_data), .slot_go(slot_go), .stat_rd(stat_rd),
    .rdy_irq_en(rdy_irq_en), .sdata(sdata), .tx_rdy(tx_rdy),
    .rdy_irq(rdy_irq), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // expected slot from the requirements (R1, R3)
  function automatic logic [19:0] exp_slot(input logic [1:0] sz, input bit le,
                                           input logic [23:0] d);
    int w;
    logic [23:0] r;
    logic [23:0] v;
    w = (sz == 2'b00) ? 10 : (sz == 2'b01) ? 16 : (sz == 2'b10) ? 18 : 20;
    r = d;
    if (le) begin
      if (w <= 16) r = {d[23:16], d[7:0], d[15:8]};
      else         r = {d[7:0], d[15:8], d[23:16]};
    end
    v = r & ((24'd1 << w) - 24'd1);
    v = v << (20 - w);
    return v[19:0];
  endfunction

  // monitor: pops one expected bit just after every rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, sdata, e);
    end
  end

  task automatic write_s(input logic [1:0] sz, input bit le, input logic [23:0] d);
    @(negedge clk);
    size_sel = sz; little_end = le; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // pulse slot_go and queue nb MSB-first bits, plus an idle low bit if tail
  task automatic slot_s(input logic [19:0] s, input int nb, input bit tail, input string t);
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      exp_q.push_back(s[19-i]);
      tag_q.push_back(t);
    end
    if (tail) begin
      exp_q.push_back(1'b0);
      tag_q.push_back("R2 idle after slot");
    end
    slot_go = 1'b1;
    @(negedge clk);
    slot_go = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic full_slot(input logic [1:0] sz, input bit le, input logic [23:0] d,
                           input string t);
    write_s(sz, le, d);
    chk("R5 write clears tx_rdy", tx_rdy, 1'b0);
    chk("R6 irq low while not ready", rdy_irq, 1'b0);
    slot_s(exp_slot(sz, le, d), 20, 1'b1, t);
    chk("R4 tx_rdy set on load", tx_rdy, 1'b1);
    chk("R6 irq follows ready", rdy_irq, 1'b1);
    drain();
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; glb_en = 1'b1; lane_en = 1'b1; size_sel = 2'b11;
    little_end = 1'b0; wr_en = 1'b0; wr_data = '0; slot_go = 1'b0;
    stat_rd = 1'b0; rdy_irq_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 reset tx_rdy", tx_rdy, 1'b1);
    chk("R6 reset irq", rdy_irq, 1'b1);
    chk("R2 reset sdata low", sdata, 1'b0);
    chk("R7 reset underrun", underrun, 1'b0);

    full_slot(2'b11, 1'b0, 24'h0ABCDE, "R2 20-bit big-endian");
    full_slot(2'b01, 1'b1, 24'h003412, "R3 16-bit swap");
    full_slot(2'b10, 1'b0, 24'h03FFFF, "R1 18-bit zero fill");
    full_slot(2'b11, 1'b1, 24'h563412, "R3 20-bit reverse");
    full_slot(2'b00, 1'b1, 24'h00AB02, "R3 10-bit swap");
    full_slot(2'b10, 1'b1, 24'h563412, "R3 18-bit reverse");
    full_slot(2'b00, 1'b0, 24'hFFF2AB, "R1 10-bit truncate");

    // R7 underrun
    slot_s(20'h0, 20, 1'b1, "R7 underrun zero slot");
    chk("R7 underrun set", underrun, 1'b1);
    drain();
    chk("R7 underrun sticky", underrun, 1'b1);
    rd_status();
    chk("R7 cleared by status read", underrun, 1'b0);

    // R8 global disable: writes and slots ignored
    glb_en = 1'b0;
    write_s(2'b11, 1'b0, 24'h012345);
    chk("R8 write ignored tx_rdy", tx_rdy, 1'b1);
    slot_s(20'h0, 20, 1'b1, "R8 no transmit when disabled");
    drain();
    chk("R8 no underrun when disabled", underrun, 1'b0);
    @(negedge clk); glb_en = 1'b1;
    slot_s(20'h0, 20, 1'b1, "R8 ignored write not held");
    chk("R8 holding empty after ignored write", underrun, 1'b1);
    drain();
    rd_status();

    // R9 channel disable mid-slot flushes holding
    write_s(2'b11, 1'b0, 24'h0FFFFF);
    slot_s(20'hFFFFF, 5, 1'b0, "R2 leading bits before disable");
    write_s(2'b11, 1'b0, 24'h011111);
    chk("R5 write during slot", tx_rdy, 1'b0);
    repeat (3) @(negedge clk);
    lane_en = 1'b0;
    @(negedge clk);
    chk("R9 sdata low after disable", sdata, 1'b0);
    chk("R9 tx_rdy set after disable", tx_rdy, 1'b1);
    lane_en = 1'b1;
    slot_s(20'h0, 20, 1'b1, "R9 flushed holding sends zeros");
    chk("R9 flush gives underrun", underrun, 1'b1);
    drain();
    rd_status();

    // R6 mask
    rdy_irq_en = 1'b0;
    @(negedge clk);
    chk("R6 masked irq low", rdy_irq, 1'b0);
    chk("R6 ready still set under mask", tx_rdy, 1'b1);
    rdy_irq_en = 1'b1;
    @(negedge clk);
    chk("R6 unmasked irq high", rdy_irq, 1'b1);

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 scoreboard left actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule